// File: doc/BRIEF.md
# Line Termination Activation Controller

This block is the layer-1 control state machine for the line-termination end of a two-wire digital subscriber transceiver. A control/indication (C/I) deserializer hands it 4-bit command codes, each with a one-cycle strobe. The receiver reports three levels: remote signal seen, synchronization reached and frame lost. A power-feed-off input reports that remote feeding has been switched off. The controller returns a 4-bit indication code, a power-up level, a transmit-signal selector, an analog-loop control and a request for a loop at the far end.

The block takes the line from powered down, through the awake, synchronize and connect-through phases, and back down again. Deactivation has two steps, a line-deactivation period followed by power down. A 1 kHz tick input clocks every timer. A single-pulse test mode sends one pulse per tick period, and each pulse has the opposite polarity to the one before it.

Top module: `lt_act_ctrl`

## Requirements
- R1: After reset, the indication is 1111 (deactivated). Power is off, the transmit selector is 0 (idle), and the analog loop, the far-end loop request and the pulse output are all inactive.
- R2: A strobed activate code 1000 in the deactivated state powers up the block. The indication becomes 1000 and the transmit selector 1 (wake). A remote signal moves the block into the synchronize phase, and the indication stays 1000 there.
- R3: Synchronization in the synchronize phase gives indication 0111 with transmit selector 2 (data). The next tick changes the indication to 1100. The indication 1100 is never entered from any code other than 0111 or 0100.
- R4: If synchronization is not reached within the window, the block returns to 1111 with power off. The window is counted in ticks from the activate command and covers the awake and synchronize phases together. It is 1000 ticks on a cold start and 170 ticks on a warm start.
- R5: Reaching synchronization makes every later activation a warm start. A strobed reset code 1101 clears this, and the next activation is cold again.
- R6: A strobed deactivate 0000, transmit-off 0011 or reset 1101 code in any powered state gives indication 0001 with transmit selector 0. On the fourth tick after that, the indication becomes 1111 and power goes off.
- R7: A frame loss during indication 1100 changes the indication to 1100→0100. Synchronization with no frame loss then restores 1100 without a new activation.
- R8: While power-feed-off is high, the block is forced powered down one cycle later, with indication 0011 and transmit selector 0, and commands are ignored. When the input falls, the indication becomes 1111.
- R9: A strobed pulse-test code 0101 in the deactivated state powers up the block with indication 1000 and transmit selector 3. Each tick then gives a one-cycle pulse. The polarity output is 0 on the first pulse and changes on every pulse after it.
- R10: A strobed analog-loop code 1001 in the deactivated state sets the analog-loop output and runs the normal activation. The loop is released when deactivation starts.
- R11: The codes 1010 and 1011 are accepted only at indication 1100. They set the far-end loop output to 01 and 10 respectively. The output returns to 00 when deactivation starts.
- R12: A code without a strobe, and any code not listed in R2 to R11, changes neither the indication nor any other output.
- R13: A listed command that does not apply in the current state is ignored; an activate at indication 1100 is one example.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 1 kHz timing strobe |
| cmd_i | input | 4 | C/I command code |
| cmd_stb_i | input | 1 | Marks cmd_i as a new command for one cycle |
| pfoff_i | input | 1 | Remote power feed switched off |
| rx_signal_i | input | 1 | Receiver detects the far-end signal |
| rx_sync_i | input | 1 | Receiver is synchronized |
| rx_frame_lost_i | input | 1 | Receiver lost frame alignment |
| ind_o | output | 4 | C/I indication code |
| pwr_up_o | output | 1 | Transceiver powered up |
| tx_sel_o | output | 2 | Transmit signal: 0 idle, 1 wake, 2 data, 3 test pulse |
| ana_loop_o | output | 1 | Transmitter looped to receiver, line disconnected |
| rmt_loop_o | output | 2 | Far-end loop request: 00 none, 01 near loop, 10 repeater loop |
| pulse_o | output | 1 | One-cycle test pulse |
| pulse_neg_o | output | 1 | Polarity of the current test pulse |

## Verification
The assertions assume that a tick never comes in two consecutive cycles, so a test pulse is always followed by a quiet cycle. They also assume that the power-feed-off input is low during reset. The bench drives every tick as one high cycle followed by at least one low cycle. It changes inputs only on falling edges and keeps the power-feed input low except in its own test. Command strobes last one cycle. The receiver levels are raised only after the state they apply to has been entered.

// File: rtl/lt_act_pkg.sv
package lt_act_pkg;

    typedef enum logic [3:0] {
        K_NONE,
        K_ACTIVATE,
        K_ANA_LOOP,
        K_LOOP_NT,
        K_LOOP_RPT,
        K_TX_OFF,
        K_DEACTIVATE,
        K_RESET,
        K_PULSE_TEST
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_AWAKE,
        ST_SYNC,
        ST_LOCKED,
        ST_THROUGH,
        ST_RESYNC,
        ST_LINE_DOWN,
        ST_PULSE
    } act_state_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_WAKE  = 2'd1,
        TX_DATA  = 2'd2,
        TX_PULSE = 2'd3
    } tx_sel_e;

    typedef enum logic [1:0] {
        RL_NONE = 2'b00,
        RL_NT   = 2'b01,
        RL_RPT  = 2'b10
    } rmt_loop_e;

    localparam logic [3:0] IND_ACT_RUN    = 4'b1000;
    localparam logic [3:0] IND_RX_SYNC    = 4'b0111;
    localparam logic [3:0] IND_THROUGH    = 4'b1100;
    localparam logic [3:0] IND_DEACT_RUN  = 4'b0001;
    localparam logic [3:0] IND_DEACT_DONE = 4'b1111;
    localparam logic [3:0] IND_RESYNC     = 4'b0100;
    localparam logic [3:0] IND_HIGH_Z     = 4'b0011;

    typedef struct packed {
        act_state_e state;
        logic       warm;
        logic       hi;
        logic       aloop;
        rmt_loop_e  rloop;
    } ctrl_t;

endpackage

// File: rtl/lt_act_cmd_dec.sv
module lt_act_cmd_dec
    import lt_act_pkg::*;
(
    input  logic [3:0] cmd_i,
    input  logic       stb_i,
    output cmd_kind_e  kind_o
);
    cmd_kind_e kind;

    always_comb begin
        case (cmd_i)
            4'b1000: kind = K_ACTIVATE;
            4'b1001: kind = K_ANA_LOOP;
            4'b1010: kind = K_LOOP_NT;
            4'b1011: kind = K_LOOP_RPT;
            4'b0011: kind = K_TX_OFF;
            4'b0000: kind = K_DEACTIVATE;
            4'b1101: kind = K_RESET;
            4'b0101: kind = K_PULSE_TEST;
            default: kind = K_NONE;
        endcase
        kind_o = stb_i ? kind : K_NONE;
    end
endmodule

// File: rtl/lt_act_timer.sv
module lt_act_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i && (cnt_q != {CNT_W{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/lt_act_pulse_gen.sv
module lt_act_pulse_gen #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic arm_i,
    input  logic tick_i,
    output logic pulse_o,
    output logic neg_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

    typedef struct packed {
        logic          pulse;
        logic          neg;
        logic          pol;
        logic [DW-1:0] div;
    } pg_t;

    pg_t pg_d, pg_q;

    always_comb begin
        pg_d       = pg_q;
        pg_d.pulse = 1'b0;
        if (start_i) begin
            pg_d.pol = 1'b0;
            pg_d.div = '0;
        end else if (arm_i && tick_i) begin
            if (pg_q.div == DIV_LAST) begin
                pg_d.div   = '0;
                pg_d.pulse = 1'b1;
                pg_d.neg   = pg_q.pol;
                pg_d.pol   = ~pg_q.pol;
            end else begin
                pg_d.div = pg_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign pulse_o = pg_q.pulse;
    assign neg_o   = pg_q.neg;
endmodule

// File: rtl/lt_act_ctrl.sv
module lt_act_ctrl
    import lt_act_pkg::*;
#(
    parameter int COLD_TICKS  = 1000,
    parameter int WARM_TICKS  = 170,
    parameter int DOWN_TICKS  = 4,
    parameter int PULSE_TICKS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [3:0] cmd_i,
    input  logic       cmd_stb_i,
    input  logic       pfoff_i,
    input  logic       rx_signal_i,
    input  logic       rx_sync_i,
    input  logic       rx_frame_lost_i,
    output logic [3:0] ind_o,
    output logic       pwr_up_o,
    output logic [1:0] tx_sel_o,
    output logic       ana_loop_o,
    output logic [1:0] rmt_loop_o,
    output logic       pulse_o,
    output logic       pulse_neg_o
);
    localparam int MAX_A = (COLD_TICKS > WARM_TICKS) ? COLD_TICKS : WARM_TICKS;
    localparam int MAX_T = (MAX_A > DOWN_TICKS) ? MAX_A : DOWN_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] COLD_LAST = CNT_W'(COLD_TICKS - 1);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARM_TICKS - 1);
    localparam logic [CNT_W-1:0] DOWN_LAST = CNT_W'(DOWN_TICKS - 1);

    ctrl_t            c_d, c_q;
    cmd_kind_e        kind;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic             moved;
    logic             tmr_clr;
    logic             pg_start, pg_arm;
    tx_sel_e          tx_sel;

    lt_act_cmd_dec u_dec (
        .cmd_i  (cmd_i),
        .stb_i  (cmd_stb_i),
        .kind_o (kind)
    );

    lt_act_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .tick_i (tick_i),
        .cnt_o  (cnt)
    );

    lt_act_pulse_gen #(.DIV(PULSE_TICKS)) u_pg (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (pg_start),
        .arm_i   (pg_arm),
        .tick_i  (tick_i),
        .pulse_o (pulse_o),
        .neg_o   (pulse_neg_o)
    );

    // next-state logic: override, then commands, then receiver and timer events
    always_comb begin
        c_d    = c_q;
        moved  = 1'b0;
        expire = tick_i && (cnt == (c_q.warm ? WARM_LAST : COLD_LAST));
        if (pfoff_i) begin
            c_d.state = ST_OFF;
            c_d.hi    = 1'b1;
        end else begin
            c_d.hi = 1'b0;
            case (kind)
                K_RESET: begin
                    c_d.warm = 1'b0;
                    if (c_q.state != ST_OFF) begin
                        c_d.state = ST_LINE_DOWN;
                        moved     = 1'b1;
                    end
                end
                K_DEACTIVATE, K_TX_OFF: begin
                    if (c_q.state != ST_OFF && c_q.state != ST_LINE_DOWN) begin
                        c_d.state = ST_LINE_DOWN;
                        moved     = 1'b1;
                    end
                end
                K_ACTIVATE, K_ANA_LOOP: begin
                    if (c_q.state == ST_OFF) begin
                        c_d.state = ST_AWAKE;
                        c_d.aloop = (kind == K_ANA_LOOP);
                        moved     = 1'b1;
                    end
                end
                K_PULSE_TEST: begin
                    if (c_q.state == ST_OFF) begin
                        c_d.state = ST_PULSE;
                        moved     = 1'b1;
                    end
                end
                K_LOOP_NT: begin
                    if (c_q.state == ST_THROUGH) c_d.rloop = RL_NT;
                end
                K_LOOP_RPT: begin
                    if (c_q.state == ST_THROUGH) c_d.rloop = RL_RPT;
                end
                default: ;
            endcase
            if (!moved) begin
                case (c_q.state)
                    ST_AWAKE: begin
                        if (expire)           c_d.state = ST_OFF;
                        else if (rx_signal_i) c_d.state = ST_SYNC;
                    end
                    ST_SYNC: begin
                        if (expire) begin
                            c_d.state = ST_OFF;
                        end else if (rx_sync_i) begin
                            c_d.state = ST_LOCKED;
                            c_d.warm  = 1'b1;
                        end
                    end
                    ST_LOCKED: begin
                        if (tick_i) c_d.state = ST_THROUGH;
                    end
                    ST_THROUGH: begin
                        if (rx_frame_lost_i) c_d.state = ST_RESYNC;
                    end
                    ST_RESYNC: begin
                        if (rx_sync_i && !rx_frame_lost_i) c_d.state = ST_THROUGH;
                    end
                    ST_LINE_DOWN: begin
                        if (tick_i && cnt == DOWN_LAST) c_d.state = ST_OFF;
                    end
                    default: ;
                endcase
            end
        end
        if (c_d.state == ST_OFF || c_d.state == ST_LINE_DOWN) begin
            c_d.aloop = 1'b0;
            c_d.rloop = RL_NONE;
        end
    end

    // the activation window spans awake and synchronize, so that step keeps counting
    assign tmr_clr  = (c_d.state != c_q.state) &&
                      !(c_q.state == ST_AWAKE && c_d.state == ST_SYNC);
    assign pg_start = (c_d.state == ST_PULSE) && (c_q.state != ST_PULSE);
    assign pg_arm   = (c_d.state == ST_PULSE) && (c_q.state == ST_PULSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: ST_OFF, warm: 1'b0, hi: 1'b0, aloop: 1'b0, rloop: RL_NONE};
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        case (c_q.state)
            ST_OFF:       ind_o = c_q.hi ? IND_HIGH_Z : IND_DEACT_DONE;
            ST_AWAKE,
            ST_SYNC,
            ST_PULSE:     ind_o = IND_ACT_RUN;
            ST_LOCKED:    ind_o = IND_RX_SYNC;
            ST_THROUGH:   ind_o = IND_THROUGH;
            ST_RESYNC:    ind_o = IND_RESYNC;
            ST_LINE_DOWN: ind_o = IND_DEACT_RUN;
            default:      ind_o = IND_DEACT_DONE;
        endcase
        case (c_q.state)
            ST_AWAKE, ST_SYNC:                 tx_sel = TX_WAKE;
            ST_LOCKED, ST_THROUGH, ST_RESYNC:  tx_sel = TX_DATA;
            ST_PULSE:                          tx_sel = TX_PULSE;
            default:                           tx_sel = TX_IDLE;
        endcase
    end

    assign pwr_up_o   = (c_q.state != ST_OFF);
    assign tx_sel_o   = tx_sel;
    assign ana_loop_o = c_q.aloop;
    assign rmt_loop_o = c_q.rloop;
endmodule

// File: rtl/lt_act_chk.sv
module lt_act_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic [3:0] cmd_i,
    input logic       cmd_stb_i,
    input logic       pfoff_i,
    input logic       rx_signal_i,
    input logic       rx_sync_i,
    input logic       rx_frame_lost_i,
    input logic [3:0] ind_o,
    input logic       pwr_up_o,
    input logic [1:0] tx_sel_o,
    input logic       ana_loop_o,
    input logic [1:0] rmt_loop_o,
    input logic       pulse_o,
    input logic       pulse_neg_o
);
    AST_WAKE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_o == 4'b1000 && $past(ind_o) == 4'b1111) |-> $past(cmd_stb_i)); // R2

    AST_THROUGH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_o == 4'b1100 && $past(ind_o) != 4'b1100) |->
        ($past(ind_o) == 4'b0111 || $past(ind_o) == 4'b0100)); // R3

    AST_POWER_DOWN_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwr_up_o) && !$past(pfoff_i)) |->
        ($past(ind_o) == 4'b0001 || $past(ind_o) == 4'b1000)); // R6

    AST_FEED_OFF_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        pfoff_i |=> (ind_o == 4'b0011 && !pwr_up_o && tx_sel_o == 2'd0)); // R8

    AST_PULSE_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (tx_sel_o == 2'd3)); // R9

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R9

    AST_LOOP_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        ana_loop_o |-> pwr_up_o); // R10

    AST_RMT_IN_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rmt_loop_o != 2'b00) |-> (ind_o == 4'b1100)); // R11
endmodule

bind lt_act_ctrl lt_act_chk u_chk (.*);

// File: tb/tb_lt_act_ctrl.sv
module tb_lt_act_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [3:0] cmd_i = 4'b0000;
    logic       cmd_stb_i = 1'b0;
    logic       pfoff_i = 1'b0;
    logic       rx_signal_i = 1'b0;
    logic       rx_sync_i = 1'b0;
    logic       rx_frame_lost_i = 1'b0;
    logic [3:0] ind_o;
    logic       pwr_up_o;
    logic [1:0] tx_sel_o;
    logic       ana_loop_o;
    logic [1:0] rmt_loop_o;
    logic       pulse_o;
    logic       pulse_neg_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lt_act_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cmd_i(cmd_i),
        .cmd_stb_i(cmd_stb_i), .pfoff_i(pfoff_i), .rx_signal_i(rx_signal_i),
        .rx_sync_i(rx_sync_i), .rx_frame_lost_i(rx_frame_lost_i),
        .ind_o(ind_o), .pwr_up_o(pwr_up_o), .tx_sel_o(tx_sel_o),
        .ana_loop_o(ana_loop_o), .rmt_loop_o(rmt_loop_o),
        .pulse_o(pulse_o), .pulse_neg_o(pulse_neg_o)
    );

    // row: cmd[4] stb pfoff sig sync lost tick | ind[4] pwr tx[2]
    localparam logic [16:0] VEC [0:16] = '{
        17'b0000_0_0_0_0_0_0_1111_0_00, // R1 idle
        17'b1000_1_0_0_0_0_0_1000_1_01, // R2 activate
        17'b0110_1_0_0_0_0_0_1000_1_01, // R12 unknown code
        17'b0000_0_0_1_0_0_0_1000_1_01, // R2 signal -> sync phase
        17'b0000_0_0_1_1_0_0_0111_1_10, // R3 synchronized
        17'b0000_0_0_1_1_0_1_1100_1_10, // R3 tick -> through
        17'b1000_1_0_1_1_0_0_1100_1_10, // R13 activate ignored
        17'b0000_0_0_1_1_1_0_0100_1_10, // R7 frame lost
        17'b0000_0_0_1_1_0_0_1100_1_10, // R7 regained
        17'b0000_1_0_1_1_0_0_0001_1_00, // R6 deactivate
        17'b0000_0_0_0_0_0_1_0001_1_00, // R6 tick 1
        17'b0000_0_0_0_0_0_0_0001_1_00,
        17'b0000_0_0_0_0_0_1_0001_1_00, // R6 tick 2
        17'b0000_0_0_0_0_0_0_0001_1_00,
        17'b0000_0_0_0_0_0_1_0001_1_00, // R6 tick 3
        17'b0000_0_0_0_0_0_0_0001_1_00,
        17'b0000_0_0_0_0_0_1_1111_0_00  // R6 tick 4 -> off
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] c);
        @(negedge clk);
        cmd_i     = c;
        cmd_stb_i = 1'b1;
        @(negedge clk);
        cmd_stb_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ind", ind_o, 4'b1111);
        chk("R1 pwr", {3'b0, pwr_up_o}, 4'd0);
        chk("R1 tx", {2'b0, tx_sel_o}, 4'd0);
        chk("R1 loops", {1'b0, ana_loop_o, rmt_loop_o}, 4'd0);
        chk("R1 pulse", {3'b0, pulse_o}, 4'd0);

        // table walk: main activation and deactivation sequence
        @(negedge clk);
        for (int i = 0; i <= 16; i++) begin
            {cmd_i, cmd_stb_i, pfoff_i, rx_signal_i, rx_sync_i, rx_frame_lost_i, tick_i} = VEC[i][16:7];
            @(negedge clk);
            chk($sformatf("row%0d ind", i), ind_o, VEC[i][6:3]);
            chk($sformatf("row%0d pwr", i), {3'b0, pwr_up_o}, {3'b0, VEC[i][2]});
            chk($sformatf("row%0d tx", i), {2'b0, tx_sel_o}, {2'b0, VEC[i][1:0]});
        end
        {cmd_stb_i, tick_i, rx_signal_i, rx_sync_i} = 4'b0000;

        // R5 warm start after the sync above: 170 tick window
        send(4'b1000);
        ticks(169);
        chk("R5 warm still running", ind_o, 4'b1000);
        ticks(1);
        chk("R5 warm timeout", ind_o, 4'b1111);
        chk("R4 power off on timeout", {3'b0, pwr_up_o}, 4'd0);

        // R5 reset clears warm memory; R4 cold window of 1000
        send(4'b1101);
        chk("R5 reset in off", ind_o, 4'b1111);
        send(4'b1000);
        ticks(170);
        chk("R5 cold after reset", ind_o, 4'b1000);
        ticks(829);
        chk("R4 cold tick 999", ind_o, 4'b1000);
        ticks(1);
        chk("R4 cold timeout", ind_o, 4'b1111);

        // R8 power feed off overrides
        send(4'b1000);
        chk("R2 activate again", ind_o, 4'b1000);
        @(negedge clk);
        pfoff_i = 1'b1;
        @(negedge clk);
        chk("R8 high-z", ind_o, 4'b0011);
        chk("R8 power off", {3'b0, pwr_up_o}, 4'd0);
        chk("R8 tx idle", {2'b0, tx_sel_o}, 4'd0);
        send(4'b1000);
        chk("R8 command ignored", ind_o, 4'b0011);
        chk("R8 command ignored pwr", {3'b0, pwr_up_o}, 4'd0);
        pfoff_i = 1'b0;
        @(negedge clk);
        chk("R8 release", ind_o, 4'b1111);

        // R9 single pulse test mode
        send(4'b0101);
        chk("R9 ind", ind_o, 4'b1000);
        chk("R9 tx", {2'b0, tx_sel_o}, 4'd3);
        chk("R9 no pulse yet", {3'b0, pulse_o}, 4'd0);
        ticks(1);
        chk("R9 pulse1", {3'b0, pulse_o}, 4'd1);
        chk("R9 pol1", {3'b0, pulse_neg_o}, 4'd0);
        @(negedge clk);
        chk("R9 pulse width", {3'b0, pulse_o}, 4'd0);
        ticks(1);
        chk("R9 pulse2", {3'b0, pulse_o}, 4'd1);
        chk("R9 pol2", {3'b0, pulse_neg_o}, 4'd1);
        ticks(1);
        chk("R9 pol3", {3'b0, pulse_neg_o}, 4'd0);
        send(4'b0011);
        chk("R6 tx-off from test", ind_o, 4'b0001);
        ticks(3);
        chk("R6 still line-down", ind_o, 4'b0001);
        ticks(1);
        chk("R6 off after 4", ind_o, 4'b1111);

        // R10 analog loop with activation, R11 far-end loops
        send(4'b1001);
        chk("R10 loop set", {3'b0, ana_loop_o}, 4'd1);
        chk("R10 awake", ind_o, 4'b1000);
        send(4'b1010);
        chk("R11 ignored outside through", {2'b0, rmt_loop_o}, 4'd0);
        @(negedge clk);
        rx_signal_i = 1'b1;
        rx_sync_i   = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R3 locked", ind_o, 4'b0111);
        ticks(1);
        chk("R3 through", ind_o, 4'b1100);
        chk("R10 loop kept", {3'b0, ana_loop_o}, 4'd1);
        send(4'b1011);
        chk("R11 repeater loop", {2'b0, rmt_loop_o}, 4'b0010);
        send(4'b1010);
        chk("R11 near loop", {2'b0, rmt_loop_o}, 4'b0001);
        send(4'b1101);
        chk("R6 reset starts down", ind_o, 4'b0001);
        chk("R10 loop released", {3'b0, ana_loop_o}, 4'd0);
        chk("R11 loop released", {2'b0, rmt_loop_o}, 4'd0);
        rx_signal_i = 1'b0;
        rx_sync_i   = 1'b0;
        ticks(4);
        chk("R6 off", ind_o, 4'b1111);

        // R12 command without strobe ignored
        @(negedge clk);
        cmd_i = 4'b1000;
        repeat (3) @(negedge clk);
        chk("R12 no strobe", ind_o, 4'b1111);
        chk("R12 no strobe pwr", {3'b0, pwr_up_o}, 4'd0);
        send(4'b1111);
        chk("R12 unknown in off", ind_o, 4'b1111);

        // R13 test-pulse command ignored while activating
        send(4'b1000);
        send(4'b0101);
        chk("R13 pulse ignored", {2'b0, tx_sel_o}, 4'd1);
        send(4'b0000);
        chk("R6 deactivate from awake", ind_o, 4'b0001);
        ticks(4);
        chk("R6 final off", ind_o, 4'b1111);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule